// File: doc/BRIEF.md
# Delayed Transaction Retry Watchdog

This block supervises the delayed transactions that a bridge forwards downstream. A delayed read and a delayed write each have their own retry counter. The counter starts when the request is issued and advances on every target retry that request receives. If the target keeps retrying up to the limit, the request is given up: the block raises a discard pulse, and the bridge then drops the request from its queue. A separate timer covers completions that have come back from the target but are not yet claimed by the originating master. If such a completion waits too long, it is discarded in the same way.

Each of the three give-up conditions sets its own sticky status bit. Software clears these bits by writing ones. A system-error pulse goes out when a condition newly sets its status bit, but only if the global error enable is on and that condition's own disable bit is off. A control input can suspend retry counting altogether. All event inputs are single-cycle pulses from the bus state machines, which are not part of this block.

Top module: `dtw_watchdog`

## Requirements
- R1: After a synchronous reset, `status`, `serr` and the three discard outputs are all 0.
- R2: A pending delayed read is discarded on its 2^RETRY_W-th counted retry since issue. `rd_discard` is high for exactly the one cycle after the edge that takes that retry.
- R3: A pending delayed write is discarded in the same way, on its own counter, through `wr_discard`.
- R4: A new issue pulse reloads that request's count to zero. A done pulse ends the pending request. Retries that arrive while nothing is pending are ignored. An issue pulse outranks a done pulse or a retry in the same cycle.
- R5: While `retry_dis` is 1, retries are not counted and cause no discard. The count reached so far is held.
- R6: When `cpl_claim` does not arrive, `cpl_discard` pulses for one cycle, TMO_CYCLES edges after the edge that takes `cpl_ready`. A claim taken on or before that edge prevents the discard. A new `cpl_ready` restarts the wait, and it outranks a claim in the same cycle.
- R7: Status bit 0 (read discard), bit 1 (write discard) and bit 2 (completion timeout) become 1 on the edge after their discard pulse and stay 1. A `clr_stb` pulse clears each bit that has a 1 in `clr_mask`. A set outranks a clear in the same cycle.
- R8: `serr` is a one-cycle pulse, in the same cycle the status bit first shows 1. It occurs only when that bit was 0 before, `err_en` is 1, and the matching bit of `cond_dis` (same bit order as `status`) is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_issue | input | 1 | Delayed read request issued downstream |
| rd_retry | input | 1 | Target retry received for the read |
| rd_done | input | 1 | Read completed successfully |
| wr_issue | input | 1 | Delayed write request issued downstream |
| wr_retry | input | 1 | Target retry received for the write |
| wr_done | input | 1 | Write completed successfully |
| cpl_ready | input | 1 | Completion is queued and waiting for its master |
| cpl_claim | input | 1 | Waiting completion has been claimed |
| retry_dis | input | 1 | Suspends retry counting |
| err_en | input | 1 | Global system-error enable |
| cond_dis | input | 3 | Per-condition error disable, status bit order |
| clr_stb | input | 1 | Write strobe for clearing status |
| clr_mask | input | 3 | Ones select status bits to clear |
| rd_discard | output | 1 | One-cycle read discard pulse |
| wr_discard | output | 1 | One-cycle write discard pulse |
| cpl_discard | output | 1 | One-cycle completion timeout discard pulse |
| status | output | 3 | Sticky status: read, write, timeout |
| serr | output | 1 | One-cycle system-error pulse |

## Verification
The assertions assume that event inputs are pulses driven from the bus side, so a discard can never repeat on the very next cycle. They also assume that control inputs such as `err_en` and `cond_dis` are sampled at the edge that produces the error pulse. The stimulus drives each event for exactly one cycle, just after an edge. It waits for every discard to appear and settle into status before starting the next scenario. It changes enables only between scenarios, so every check sees a single cause.

// File: rtl/dtw_pkg.sv
package dtw_pkg;
  localparam int unsigned NCOND = 3;
  localparam int unsigned C_RD  = 0;
  localparam int unsigned C_WR  = 1;
  localparam int unsigned C_TO  = 2;
  typedef logic [NCOND-1:0] cond_vec_t;
endpackage

// File: rtl/dtw_retry_cnt.sv
module dtw_retry_cnt #(
  parameter int CNT_W = 24
) (
  input  logic clk,
  input  logic rst,
  input  logic issue,
  input  logic retry,
  input  logic done,
  input  logic cnt_en,
  output logic discard
);
  localparam logic [CNT_W-1:0] LAST = '1;

  logic [CNT_W-1:0] cnt;
  logic             pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      pend    <= 1'b0;
      discard <= 1'b0;
    end else begin
      discard <= 1'b0;
      if (issue) begin
        pend <= 1'b1;
        cnt  <= '0;
      end else if (done) begin
        pend <= 1'b0;
        cnt  <= '0;
      end else if (pend && retry && cnt_en) begin
        if (cnt == LAST) begin
          pend    <= 1'b0;
          cnt     <= '0;
          discard <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dtw_mto_timer.sv
module dtw_mto_timer #(
  parameter int TMO_CYCLES = 32768
) (
  input  logic clk,
  input  logic rst,
  input  logic ready,
  input  logic claim,
  output logic expire
);
  localparam int CW = $clog2(TMO_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(TMO_CYCLES - 1);

  logic [CW-1:0] cnt;
  logic          active;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      active <= 1'b0;
      expire <= 1'b0;
    end else begin
      expire <= 1'b0;
      if (ready) begin
        active <= 1'b1;
        cnt    <= '0;
      end else if (claim) begin
        active <= 1'b0;
        cnt    <= '0;
      end else if (active) begin
        if (cnt == LAST) begin
          active <= 1'b0;
          cnt    <= '0;
          expire <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dtw_status.sv
module dtw_status
  import dtw_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  cond_vec_t events,
  input  logic      clr_stb,
  input  cond_vec_t clr_mask,
  input  logic      err_en,
  input  cond_vec_t cond_dis,
  output cond_vec_t status,
  output logic      serr
);
  cond_vec_t fresh;
  cond_vec_t clr_bits;

  always_comb begin
    fresh    = events & ~status;
    clr_bits = clr_stb ? clr_mask : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      serr   <= 1'b0;
    end else begin
      status <= (status & ~clr_bits) | events;
      serr   <= err_en && ((fresh & ~cond_dis) != '0);
    end
  end
endmodule

// File: rtl/dtw_watchdog.sv
module dtw_watchdog
  import dtw_pkg::*;
#(
  parameter int RETRY_W    = 24,
  parameter int TMO_CYCLES = 32768
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rd_issue,
  input  logic       rd_retry,
  input  logic       rd_done,
  input  logic       wr_issue,
  input  logic       wr_retry,
  input  logic       wr_done,
  input  logic       cpl_ready,
  input  logic       cpl_claim,
  input  logic       retry_dis,
  input  logic       err_en,
  input  logic [2:0] cond_dis,
  input  logic       clr_stb,
  input  logic [2:0] clr_mask,
  output logic       rd_discard,
  output logic       wr_discard,
  output logic       cpl_discard,
  output logic [2:0] status,
  output logic       serr
);
  localparam int NREQ = 2;

  logic [NREQ-1:0] req_issue, req_retry, req_done, req_disc;
  cond_vec_t       events;

  assign req_issue = {wr_issue, rd_issue};
  assign req_retry = {wr_retry, rd_retry};
  assign req_done  = {wr_done,  rd_done};

  for (genvar g = 0; g < NREQ; g++) begin : g_req
    dtw_retry_cnt #(.CNT_W(RETRY_W)) u_cnt (
      .clk     (clk),
      .rst     (rst),
      .issue   (req_issue[g]),
      .retry   (req_retry[g]),
      .done    (req_done[g]),
      .cnt_en  (!retry_dis),
      .discard (req_disc[g])
    );
  end

  dtw_mto_timer #(.TMO_CYCLES(TMO_CYCLES)) u_tmo (
    .clk    (clk),
    .rst    (rst),
    .ready  (cpl_ready),
    .claim  (cpl_claim),
    .expire (cpl_discard)
  );

  assign rd_discard     = req_disc[C_RD];
  assign wr_discard     = req_disc[C_WR];
  assign events[C_RD]   = req_disc[C_RD];
  assign events[C_WR]   = req_disc[C_WR];
  assign events[C_TO]   = cpl_discard;

  dtw_status u_stat (
    .clk      (clk),
    .rst      (rst),
    .events   (events),
    .clr_stb  (clr_stb),
    .clr_mask (clr_mask),
    .err_en   (err_en),
    .cond_dis (cond_dis),
    .status   (status),
    .serr     (serr)
  );
endmodule

// File: rtl/dtw_watchdog_chk.sv
module dtw_watchdog_chk (
  input logic       clk,
  input logic       rst,
  input logic       retry_dis,
  input logic       err_en,
  input logic       clr_stb,
  input logic [2:0] clr_mask,
  input logic       rd_discard,
  input logic       wr_discard,
  input logic       cpl_discard,
  input logic [2:0] status,
  input logic       serr
);
  assert_rd_sets_status_R2: assert property (@(posedge clk) disable iff (rst)
    rd_discard |=> status[0]);
  assert_rd_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    rd_discard |=> !rd_discard);
  assert_wr_sets_status_R3: assert property (@(posedge clk) disable iff (rst)
    wr_discard |=> status[1]);
  assert_no_count_when_off_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_discard || wr_discard) |-> $past(!retry_dis));
  assert_to_sets_status_R6: assert property (@(posedge clk) disable iff (rst)
    cpl_discard |=> status[2]);
  assert_to_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    cpl_discard |=> !cpl_discard);
  assert_fall_needs_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (($past(status) & ~status & ~($past(clr_mask) & {3{$past(clr_stb)}})) == 3'b000));
  assert_serr_enabled_R8: assert property (@(posedge clk) disable iff (rst)
    serr |-> $past(err_en));
  assert_serr_new_bit_R8: assert property (@(posedge clk) disable iff (rst)
    serr |-> ((status & ~$past(status)) != 3'b000));
endmodule

bind dtw_watchdog dtw_watchdog_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .retry_dis   (retry_dis),
  .err_en      (err_en),
  .clr_stb     (clr_stb),
  .clr_mask    (clr_mask),
  .rd_discard  (rd_discard),
  .wr_discard  (wr_discard),
  .cpl_discard (cpl_discard),
  .status      (status),
  .serr        (serr)
);

// File: tb/sim_dtw_watchdog.sv
`timescale 1ns/1ps
module sim_dtw_watchdog;
  localparam int RW = 3;
  localparam int NR = 1 << RW;
  localparam int TL = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rd_issue = 0, rd_retry = 0, rd_done = 0;
  logic wr_issue = 0, wr_retry = 0, wr_done = 0;
  logic cpl_ready = 0, cpl_claim = 0;
  logic retry_dis = 0, err_en = 0, clr_stb = 0;
  logic [2:0] cond_dis = 3'b000, clr_mask = 3'b000;
  logic rd_discard, wr_discard, cpl_discard, serr;
  logic [2:0] status;

  int n_chk = 0, n_err = 0;
  int c_rd = 0, c_wr = 0, c_to = 0, c_serr = 0;

  always #4 clk = ~clk;

  dtw_watchdog #(.RETRY_W(RW), .TMO_CYCLES(TL)) u0 (.*);

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    #1;
    rd_issue = 0; rd_retry = 0; rd_done = 0;
    wr_issue = 0; wr_retry = 0; wr_done = 0;
    cpl_ready = 0; cpl_claim = 0; clr_stb = 0;
    c_rd   += int'(rd_discard);
    c_wr   += int'(wr_discard);
    c_to   += int'(cpl_discard);
    c_serr += int'(serr);
  endtask

  task automatic zero_counts();
    c_rd = 0; c_wr = 0; c_to = 0; c_serr = 0;
  endtask

  task automatic clear_all();
    clr_stb = 1; clr_mask = 3'b111;
    cycle();
    clr_mask = 3'b000;
  endtask

  task automatic retry_run(input bit wr, input int n, input int gap, output int at);
    at = 0;
    if (wr) wr_issue = 1; else rd_issue = 1;
    cycle();
    for (int i = 1; i <= n; i++) begin
      if (wr) wr_retry = 1; else rd_retry = 1;
      cycle();
      if ((wr ? wr_discard : rd_discard) && at == 0) at = i;
      repeat (gap) cycle();
    end
    cycle();
    cycle();
    if (wr) wr_done = 1; else rd_done = 1;
    cycle();
  endtask

  task automatic trig(input int c);
    if (c == 2) begin
      cpl_ready = 1;
      cycle();
      repeat (TL) cycle();
    end else begin
      if (c == 1) wr_issue = 1; else rd_issue = 1;
      cycle();
      repeat (NR) begin
        if (c == 1) wr_retry = 1; else rd_retry = 1;
        cycle();
      end
    end
  endtask

  initial begin
    #(8 * 200000);
    n_err++;
    n_chk++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int at;
    repeat (3) cycle();
    rst = 0;
    cycle();
    check("R1 status", int'(status), 0);
    check("R1 serr", int'(serr), 0);
    check("R1 discards", int'({rd_discard, wr_discard, cpl_discard}), 0);

    // R2 / R3: sweep retry counts and spacing
    for (int wr = 0; wr < 2; wr++)
      for (int n = 0; n <= NR + 2; n++)
        for (int gap = 0; gap < 2; gap++) begin
          zero_counts();
          retry_run(wr[0], n, gap, at);
          check(wr ? "R3 discard count" : "R2 discard count",
                wr ? c_wr : c_rd, (n >= NR) ? 1 : 0);
          check(wr ? "R3 discard retry index" : "R2 discard retry index",
                at, (n >= NR) ? NR : 0);
          check(wr ? "R3 status bit1" : "R2 status bit0",
                int'(status[wr]), (n >= NR) ? 1 : 0);
          check("R3 other counter untouched", wr ? c_rd : c_wr, 0);
          clear_all();
        end

    // R4: reissue reloads, done ends, idle retries ignored
    zero_counts();
    rd_issue = 1; cycle();
    repeat (NR - 1) begin rd_retry = 1; cycle(); end
    rd_issue = 1; rd_retry = 1; cycle();
    repeat (NR - 1) begin rd_retry = 1; cycle(); end
    cycle();
    check("R4 reissue reload", c_rd, 0);
    rd_retry = 1; cycle(); cycle();
    check("R4 final retry after reload", c_rd, 1);
    zero_counts();
    wr_issue = 1; cycle();
    repeat (NR - 1) begin wr_retry = 1; cycle(); end
    wr_done = 1; cycle();
    repeat (2 * NR) begin wr_retry = 1; cycle(); end
    cycle();
    check("R4 retries after done ignored", c_wr, 0);
    clear_all();

    // R5: counting suspended
    zero_counts();
    retry_dis = 1;
    rd_issue = 1; cycle();
    repeat (NR + 4) begin rd_retry = 1; cycle(); end
    cycle();
    check("R5 no discard while disabled", c_rd, 0);
    check("R5 status untouched", int'(status), 0);
    retry_dis = 0;
    repeat (NR) begin rd_retry = 1; cycle(); end
    cycle();
    check("R5 count held, resumes", c_rd, 1);
    clear_all();

    // R6: claim position sweep
    for (int k = 1; k <= TL + 2; k++) begin
      zero_counts();
      at = 0;
      cpl_ready = 1; cycle();
      for (int j = 1; j <= TL + 2; j++) begin
        if (j == k) cpl_claim = 1;
        cycle();
        if (cpl_discard && at == 0) at = j;
      end
      cycle();
      check("R6 timeout count", c_to, (k > TL) ? 1 : 0);
      check("R6 timeout cycle", at, (k > TL) ? TL : 0);
      check("R6 status bit2", int'(status[2]), (k > TL) ? 1 : 0);
      clear_all();
    end
    zero_counts();
    at = 0;
    cpl_ready = 1; cycle();
    repeat (3) cycle();
    cpl_ready = 1; cycle();
    for (int j = 1; j <= TL + 2; j++) begin
      cycle();
      if (cpl_discard && at == 0) at = j;
    end
    check("R6 ready restarts wait", at, TL);
    check("R6 single discard after restart", c_to, 1);
    clear_all();

    // R8: enable / disable sweep per condition
    for (int e = 0; e < 2; e++)
      for (int d = 0; d < 2; d++)
        for (int c = 0; c < 3; c++) begin
          clear_all();
          err_en = e[0];
          cond_dis = 3'b000;
          cond_dis[c] = d[0];
          zero_counts();
          trig(c);
          cycle(); cycle();
          check("R8 serr gating", c_serr, (e == 1 && d == 0) ? 1 : 0);
          check("R7 bit set regardless of gating", int'(status[c]), 1);
          zero_counts();
          trig(c);
          cycle(); cycle();
          check("R8 no serr when bit already set", c_serr, 0);
        end
    err_en = 0; cond_dis = 3'b000;
    clear_all();

    // R7: sticky, selective clear, set beats clear
    trig(0); trig(1); trig(2); cycle();
    check("R7 all bits sticky", int'(status), 7);
    clr_stb = 1; clr_mask = 3'b010; cycle();
    check("R7 selective clear", int'(status), 5);
    clr_mask = 3'b111; cycle();
    check("R7 mask without strobe ignored", int'(status), 5);
    clear_all();
    check("R7 full clear", int'(status), 0);
    trig(0);
    clr_stb = 1; clr_mask = 3'b001; cycle();
    check("R7 set wins over clear", int'(status[0]), 1);
    clear_all();

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule